// File: doc/BRIEF.md
# Interrupt Stack Frame Sequencer

This block carries out the stack side of taking and leaving an interrupt in a protected-mode processor model. When an entry request arrives, it compares the privilege bits of the current code selector with those of the handler's code selector. From that comparison it picks the stack to use: the current one for a handler at the same level, or the inner stack pair for a handler at a more privileged level. It then writes the saved-state frame to a 32-bit memory port, one word per cycle, counting the stack pointer down as it goes. An entry that would land in a less privileged ring is refused: a fault is flagged and nothing is written.

When a return request arrives, the block reads the frame back, starting at the current stack pointer. It first takes the instruction pointer, the code selector and the flags word. It reads the outer stack pointer and stack selector only when the popped code selector shows a less privileged ring than the current one. When the operation finishes, it pulses `done` once and presents the resulting selectors, pointers and flags. It also decodes the resulting code selector into its table bit, its byte offset into the table and its privilege level.

Memory reads are synchronous. Read data is taken one cycle after the cycle in which `mem_re` is high.

Top module: `intr_frame_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `fault`, `mem_we` and `mem_re` are low, and every result output is zero.
- R2: Entry to a handler at the same ring writes three words: the flags word at the current stack pointer minus 4, the code selector at minus 8, and the instruction pointer at minus 12. `out_esp` is the address of the last word written, and `out_ss` keeps the current stack selector.
- R3: Entry to a handler at a more privileged ring switches to the inner stack pair. It writes the old stack selector at inner pointer minus 4, then the old stack pointer, the flags, the code selector and the instruction pointer at successive lower addresses. `out_ss` is the inner stack selector.
- R4: When `has_err` is high on entry, `err_code` is written after the instruction pointer, one word lower, and the frame grows by one word.
- R5: A selector takes a full 32-bit word: written with bits 31..16 zero, and bits 31..16 ignored when read back.
- R6: An entry request whose handler ring number is higher than the current ring gives `done` with `fault` high and no memory write. The results are the unchanged current values.
- R7: A return to the same ring reads the instruction pointer at `cur_esp`, the code selector at +4 and the flags at +8. `out_esp` is `cur_esp`+12 and `out_ss` is `cur_ss`.
- R8: When the popped code selector's ring number is higher than the current ring, the return also reads the outer stack pointer at +12 and the stack selector at +16, and presents them as `out_esp` and `out_ss`.
- R9: When the popped code selector's ring number is lower than the current ring, the return stops after three reads and raises `fault` with `done`. `out_esp` is `cur_esp`+12.
- R10: The block never asserts `mem_we` and `mem_re` together, and asserts neither while `busy` is low. Entry writes fall on consecutive cycles, and return reads fall two cycles apart.
- R11: `done` lasts exactly one cycle. Requests are ignored while `busy` is high. If both requests are high while idle, the entry is performed.
- R12: Selector bits 1..0 are the ring, bit 2 is the table select, and bits 15..3 are the index. `out_cs_table` is bit 2 of `out_cs`, `out_cs_off` is the index times 8 (bits 2..0 cleared), and `out_cpl` is bits 1..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| entry_req | input | 1 | Start an interrupt entry (sampled while idle) |
| ret_req | input | 1 | Start an interrupt return (sampled while idle) |
| has_err | input | 1 | Entry carries an error code |
| cur_ss | input | 16 | Current stack selector |
| cur_esp | input | 32 | Current stack pointer |
| cur_eflags | input | 32 | Current flags word |
| cur_cs | input | 16 | Current code selector; bits 1..0 give the current ring |
| cur_eip | input | 32 | Current instruction pointer |
| err_code | input | 32 | Error code for entry |
| inner_ss | input | 16 | Inner stack selector from the task state |
| inner_esp | input | 32 | Inner stack pointer from the task state |
| handler_cs | input | 16 | Handler code selector; bits 1..0 give the target ring |
| handler_eip | input | 32 | Handler instruction pointer |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Stack read strobe |
| mem_addr | output | 32 | Stack byte address |
| mem_wdata | output | 32 | Stack write data |
| mem_rdata | input | 32 | Stack read data, valid the cycle after `mem_re` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Privilege fault, valid with `done` |
| out_ss | output | 16 | Resulting stack selector |
| out_esp | output | 32 | Resulting stack pointer |
| out_eflags | output | 32 | Resulting flags word |
| out_cs | output | 16 | Resulting code selector |
| out_eip | output | 32 | Resulting instruction pointer |
| out_cs_table | output | 1 | Table select bit of `out_cs` |
| out_cs_off | output | 16 | Byte offset of `out_cs` in its table |
| out_cpl | output | 2 | Ring of `out_cs` |

## Verification
A wrong slot counter or a wrong ring comparison shows up first on the memory port. A write address that does not step down by 4, a missing or extra word, or a read at an address that was never expected appears in the very cycle the strobe rises, well before `done`. A wrong choice of stack or a wrong outer-return decision also appears there: the first write address moves to the wrong stack at once, and a return makes a fourth read it should not make, or misses one it should. Corruption in the captured values is visible only at the `done` pulse, where every result output is compared against a frame rebuilt from the requirements.

// File: rtl/ifs_pkg.sv
package ifs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_RWAIT,
    ST_RCAPT,
    ST_FIN
  } seq_state_t;

  // Frame word positions, highest address first; entry walks up, return walks down.
  localparam logic [2:0] SL_SS  = 3'd0;
  localparam logic [2:0] SL_ESP = 3'd1;
  localparam logic [2:0] SL_EFL = 3'd2;
  localparam logic [2:0] SL_CS  = 3'd3;
  localparam logic [2:0] SL_EIP = 3'd4;
  localparam logic [2:0] SL_ERR = 3'd5;
endpackage

// File: rtl/ifs_sel_decode.sv
module ifs_sel_decode #(
  parameter int SELW = 16
) (
  input  logic [SELW-1:0] sel,
  output logic            tbl,
  output logic [SELW-1:0] off,
  output logic [1:0]      rpl
);
  // Entries are 8 bytes, so clearing the low three bits gives the byte offset.
  assign off = {sel[SELW-1:3], 3'b000};
  assign tbl = sel[2];
  assign rpl = sel[1:0];
endmodule

// File: rtl/ifs_frame_word.sv
module ifs_frame_word #(
  parameter int W    = 32,
  parameter int SELW = 16
) (
  input  logic [2:0]      slot,
  input  logic [SELW-1:0] ss,
  input  logic [W-1:0]    esp,
  input  logic [W-1:0]    eflags,
  input  logic [SELW-1:0] cs,
  input  logic [W-1:0]    eip,
  input  logic [W-1:0]    err,
  output logic [W-1:0]    word
);
  import ifs_pkg::*;
  localparam int PADW = W - SELW;

  always_comb begin
    unique case (slot)
      SL_SS:   word = {{PADW{1'b0}}, ss};
      SL_ESP:  word = esp;
      SL_EFL:  word = eflags;
      SL_CS:   word = {{PADW{1'b0}}, cs};
      SL_EIP:  word = eip;
      SL_ERR:  word = err;
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/ifs_ring_cmp.sv
module ifs_ring_cmp (
  input  logic [1:0] from_r,
  input  logic [1:0] to_r,
  output logic       lt,
  output logic       gt
);
  assign lt = (to_r < from_r);
  assign gt = (to_r > from_r);
endmodule

// File: rtl/intr_frame_seq.sv
module intr_frame_seq #(
  parameter int W    = 32,
  parameter int SELW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            entry_req,
  input  logic            ret_req,
  input  logic            has_err,
  input  logic [SELW-1:0] cur_ss,
  input  logic [W-1:0]    cur_esp,
  input  logic [W-1:0]    cur_eflags,
  input  logic [SELW-1:0] cur_cs,
  input  logic [W-1:0]    cur_eip,
  input  logic [W-1:0]    err_code,
  input  logic [SELW-1:0] inner_ss,
  input  logic [W-1:0]    inner_esp,
  input  logic [SELW-1:0] handler_cs,
  input  logic [W-1:0]    handler_eip,
  output logic            mem_we,
  output logic            mem_re,
  output logic [W-1:0]    mem_addr,
  output logic [W-1:0]    mem_wdata,
  input  logic [W-1:0]    mem_rdata,
  output logic            busy,
  output logic            done,
  output logic            fault,
  output logic [SELW-1:0] out_ss,
  output logic [W-1:0]    out_esp,
  output logic [W-1:0]    out_eflags,
  output logic [SELW-1:0] out_cs,
  output logic [W-1:0]    out_eip,
  output logic            out_cs_table,
  output logic [SELW-1:0] out_cs_off,
  output logic [1:0]      out_cpl
);
  import ifs_pkg::*;

  localparam logic [W-1:0] STEP = W'(W / 8);

  seq_state_t      st;
  logic [2:0]      slot, slot_end;
  logic [W-1:0]    sp;
  logic            op_ent, chg, flt, outer;
  // entry snapshot
  logic [SELW-1:0] s_ss, s_cs, s_hcs, s_iss;
  logic [W-1:0]    s_esp, s_efl, s_eip, s_err, s_heip;
  // popped frame
  logic [SELW-1:0] p_ss, p_cs;
  logic [W-1:0]    p_esp, p_efl, p_eip;
  // registered outputs
  logic            we_q, re_q, done_q, fault_q;
  logic [W-1:0]    addr_q, wdata_q;
  logic [SELW-1:0] o_ss, o_cs;
  logic [W-1:0]    o_esp, o_efl, o_eip;

  logic            ent_lt, ent_gt, ret_lt, ret_gt;
  logic [W-1:0]    push_word;

  ifs_ring_cmp u_ent_cmp (
    .from_r (cur_cs[1:0]),
    .to_r   (handler_cs[1:0]),
    .lt     (ent_lt),
    .gt     (ent_gt)
  );

  ifs_ring_cmp u_ret_cmp (
    .from_r (s_cs[1:0]),
    .to_r   (p_cs[1:0]),
    .lt     (ret_lt),
    .gt     (ret_gt)
  );

  ifs_frame_word #(.W(W), .SELW(SELW)) u_word (
    .slot   (slot),
    .ss     (s_ss),
    .esp    (s_esp),
    .eflags (s_efl),
    .cs     (s_cs),
    .eip    (s_eip),
    .err    (s_err),
    .word   (push_word)
  );

  ifs_sel_decode #(.SELW(SELW)) u_out_dec (
    .sel (o_cs),
    .tbl (out_cs_table),
    .off (out_cs_off),
    .rpl (out_cpl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      slot     <= '0;
      slot_end <= '0;
      sp       <= '0;
      op_ent   <= 1'b0;
      chg      <= 1'b0;
      flt      <= 1'b0;
      outer    <= 1'b0;
      s_ss     <= '0;
      s_cs     <= '0;
      s_hcs    <= '0;
      s_iss    <= '0;
      s_esp    <= '0;
      s_efl    <= '0;
      s_eip    <= '0;
      s_err    <= '0;
      s_heip   <= '0;
      p_ss     <= '0;
      p_cs     <= '0;
      p_esp    <= '0;
      p_efl    <= '0;
      p_eip    <= '0;
      we_q     <= 1'b0;
      re_q     <= 1'b0;
      done_q   <= 1'b0;
      fault_q  <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      o_ss     <= '0;
      o_cs     <= '0;
      o_esp    <= '0;
      o_efl    <= '0;
      o_eip    <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          we_q <= 1'b0;
          re_q <= 1'b0;
          if (entry_req) begin
            op_ent   <= 1'b1;
            s_ss     <= cur_ss;
            s_esp    <= cur_esp;
            s_efl    <= cur_eflags;
            s_cs     <= cur_cs;
            s_eip    <= cur_eip;
            s_err    <= err_code;
            s_hcs    <= handler_cs;
            s_heip   <= handler_eip;
            s_iss    <= inner_ss;
            chg      <= ent_lt;
            flt      <= ent_gt;
            sp       <= ent_lt ? inner_esp : cur_esp;
            slot     <= ent_lt ? SL_SS : SL_EFL;
            slot_end <= has_err ? SL_ERR : SL_EIP;
            st       <= ent_gt ? ST_FIN : ST_PUSH;
          end else if (ret_req) begin
            op_ent <= 1'b0;
            s_ss   <= cur_ss;
            s_cs   <= cur_cs;
            flt    <= 1'b0;
            outer  <= 1'b0;
            re_q   <= 1'b1;
            addr_q <= cur_esp;
            sp     <= cur_esp + STEP;
            slot   <= SL_EIP;
            st     <= ST_RWAIT;
          end
        end
        ST_PUSH: begin
          we_q    <= 1'b1;
          addr_q  <= sp - STEP;
          wdata_q <= push_word;
          sp      <= sp - STEP;
          if (slot == slot_end) st <= ST_FIN;
          else slot <= slot + 3'd1;
        end
        ST_RWAIT: begin
          re_q <= 1'b0;
          st   <= ST_RCAPT;
        end
        ST_RCAPT: begin
          // default: issue the next pop
          re_q   <= 1'b1;
          addr_q <= sp;
          sp     <= sp + STEP;
          slot   <= slot - 3'd1;
          st     <= ST_RWAIT;
          unique case (slot)
            SL_EIP: p_eip <= mem_rdata;
            SL_CS:  p_cs  <= mem_rdata[SELW-1:0];
            SL_EFL: begin
              p_efl <= mem_rdata;
              if (ret_gt) begin
                outer <= 1'b1;
              end else begin
                flt  <= ret_lt;
                re_q <= 1'b0;
                sp   <= sp;
                slot <= slot;
                st   <= ST_FIN;
              end
            end
            SL_ESP: p_esp <= mem_rdata;
            default: begin
              p_ss <= mem_rdata[SELW-1:0];
              re_q <= 1'b0;
              sp   <= sp;
              slot <= slot;
              st   <= ST_FIN;
            end
          endcase
        end
        ST_FIN: begin
          we_q    <= 1'b0;
          re_q    <= 1'b0;
          done_q  <= 1'b1;
          fault_q <= flt;
          st      <= ST_IDLE;
          if (op_ent) begin
            o_ss  <= (chg && !flt) ? s_iss : s_ss;
            o_esp <= sp;
            o_efl <= s_efl;
            o_cs  <= flt ? s_cs : s_hcs;
            o_eip <= flt ? s_eip : s_heip;
          end else begin
            o_ss  <= outer ? p_ss : s_ss;
            o_esp <= outer ? p_esp : sp;
            o_efl <= p_efl;
            o_cs  <= p_cs;
            o_eip <= p_eip;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (st != ST_IDLE);
  assign done       = done_q;
  assign fault      = fault_q;
  assign mem_we     = we_q;
  assign mem_re     = re_q;
  assign mem_addr   = addr_q;
  assign mem_wdata  = wdata_q;
  assign out_ss     = o_ss;
  assign out_esp    = o_esp;
  assign out_eflags = o_efl;
  assign out_cs     = o_cs;
  assign out_eip    = o_eip;
endmodule

// File: rtl/ifs_chk.sv
module ifs_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         entry_req,
  input logic         ret_req,
  input logic         busy,
  input logic         done,
  input logic         fault,
  input logic         mem_we,
  input logic         mem_re,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] out_esp
);
  localparam logic [W-1:0] STEP = W'(W / 8);

  logic         c_entry;
  logic [3:0]   c_wcnt;
  logic [W-1:0] c_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_entry <= 1'b0;
      c_wcnt  <= '0;
      c_last  <= '0;
    end else if (!busy && (entry_req || ret_req)) begin
      c_entry <= entry_req;
      c_wcnt  <= '0;
    end else if (mem_we) begin
      c_wcnt <= c_wcnt + 4'd1;
      c_last <= mem_addr;
    end
  end

  a_r10_no_we_and_re: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_we && !mem_re));

  a_r2_push_steps_down: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - STEP));

  a_r7_pop_steps_up: assert property (@(posedge clk) disable iff (rst)
    (mem_re && $past(mem_re, 2)) |-> (mem_addr == $past(mem_addr, 2) + STEP));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_fault_no_write: assert property (@(posedge clk) disable iff (rst)
    (done && fault && c_entry) |-> (c_wcnt == 4'd0));

  a_r4_frame_len: assert property (@(posedge clk) disable iff (rst)
    (done && !fault && c_entry) |-> (c_wcnt >= 4'd3 && c_wcnt <= 4'd6));

  a_r2_final_sp: assert property (@(posedge clk) disable iff (rst)
    (done && !fault && c_entry) |-> (out_esp == c_last));
endmodule

bind intr_frame_seq ifs_chk #(.W(W)) u_ifs_chk (
  .clk       (clk),
  .rst       (rst),
  .entry_req (entry_req),
  .ret_req   (ret_req),
  .busy      (busy),
  .done      (done),
  .fault     (fault),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .mem_addr  (mem_addr),
  .out_esp   (out_esp)
);

// File: tb/intr_frame_seq_bench.sv
module intr_frame_seq_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, entry_req, ret_req, has_err;
  logic [15:0] cur_ss, cur_cs, inner_ss, handler_cs;
  logic [31:0] cur_esp, cur_eflags, cur_eip, err_code, inner_esp, handler_eip;
  logic        mem_we, mem_re, busy, done, fault, out_cs_table;
  logic [31:0] mem_addr, mem_wdata, out_esp, out_eflags, out_eip;
  logic [31:0] mem_rdata = 32'h0;
  logic [15:0] out_ss, out_cs, out_cs_off;
  logic [1:0]  out_cpl;

  intr_frame_seq u_intr_frame_seq (
    .clk(clk), .rst(rst), .entry_req(entry_req), .ret_req(ret_req), .has_err(has_err),
    .cur_ss(cur_ss), .cur_esp(cur_esp), .cur_eflags(cur_eflags), .cur_cs(cur_cs),
    .cur_eip(cur_eip), .err_code(err_code), .inner_ss(inner_ss), .inner_esp(inner_esp),
    .handler_cs(handler_cs), .handler_eip(handler_eip), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy),
    .done(done), .fault(fault), .out_ss(out_ss), .out_esp(out_esp), .out_eflags(out_eflags),
    .out_cs(out_cs), .out_eip(out_eip), .out_cs_table(out_cs_table),
    .out_cs_off(out_cs_off), .out_cpl(out_cpl)
  );

  // behavioural stack memory
  logic [31:0] mem [logic [31:0]];
  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction
  always @(posedge clk) begin
    if (mem_re) mem_rdata <= rd(mem_addr);
    if (mem_we) mem[mem_addr] = mem_wdata;
  end

  int checks = 0, fails = 0;
  string cur_tag = "R1";
  logic [31:0] exp_wa[$], exp_wd[$], exp_ra[$];
  logic [15:0] e_ss, e_cs;
  logic [31:0] e_esp, e_efl, e_eip;
  logic        e_fault;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", cur_tag, what, act, exp);
    end
  endtask

  // per-clock comparison of the memory port against the reference queues (R10)
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_we && mem_re) chk(1'b0, "R10 write and read together", 32'h1, 32'h0);
      if (!busy && (mem_we || mem_re)) chk(1'b0, "R10 access while idle", 32'h1, 32'h0);
      if (mem_we) begin
        if (exp_wa.size() == 0) chk(1'b0, "unexpected write", mem_addr, 32'h0);
        else begin
          logic [31:0] a, d;
          a = exp_wa.pop_front();
          d = exp_wd.pop_front();
          chk(mem_addr == a, "write address", mem_addr, a);
          chk(mem_wdata == d, "write data", mem_wdata, d);
        end
      end
      if (mem_re) begin
        if (exp_ra.size() == 0) chk(1'b0, "unexpected read", mem_addr, 32'h0);
        else begin
          logic [31:0] a;
          a = exp_ra.pop_front();
          chk(mem_addr == a, "read address", mem_addr, a);
        end
      end
    end
  end

  task automatic model_entry();
    logic [31:0] words[$];
    logic [31:0] p;
    bit inward, outward;
    inward  = handler_cs[1:0] < cur_cs[1:0];
    outward = handler_cs[1:0] > cur_cs[1:0];
    e_efl = cur_eflags;
    if (outward) begin
      e_fault = 1'b1; e_ss = cur_ss; e_esp = cur_esp; e_cs = cur_cs; e_eip = cur_eip;
    end else begin
      p = inward ? inner_esp : cur_esp;
      if (inward) begin
        words.push_back({16'h0, cur_ss});
        words.push_back(cur_esp);
      end
      words.push_back(cur_eflags);
      words.push_back({16'h0, cur_cs});
      words.push_back(cur_eip);
      if (has_err) words.push_back(err_code);
      foreach (words[i]) begin
        p = p - 32'd4;
        exp_wa.push_back(p);
        exp_wd.push_back(words[i]);
      end
      e_fault = 1'b0; e_ss = inward ? inner_ss : cur_ss; e_esp = p;
      e_cs = handler_cs; e_eip = handler_eip;
    end
  endtask

  task automatic model_ret();
    logic [15:0] pcs;
    e_eip = rd(cur_esp);
    pcs = rd(cur_esp + 32'd4)[15:0];
    e_efl = rd(cur_esp + 32'd8);
    e_cs = pcs;
    for (int k = 0; k < 3; k++) exp_ra.push_back(cur_esp + 32'(4 * k));
    if (pcs[1:0] > cur_cs[1:0]) begin
      exp_ra.push_back(cur_esp + 32'd12);
      exp_ra.push_back(cur_esp + 32'd16);
      e_esp = rd(cur_esp + 32'd12);
      e_ss = rd(cur_esp + 32'd16)[15:0];
      e_fault = 1'b0;
    end else begin
      e_esp = cur_esp + 32'd12;
      e_ss = cur_ss;
      e_fault = (pcs[1:0] < cur_cs[1:0]);
    end
  endtask

  task automatic wait_and_compare();
    int n = 0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(done, "done seen", 32'(done), 32'h1);
    chk(fault == e_fault, "fault", 32'(fault), 32'(e_fault));
    chk(out_ss == e_ss, "out_ss", 32'(out_ss), 32'(e_ss));
    chk(out_esp == e_esp, "out_esp", out_esp, e_esp);
    chk(out_eflags == e_efl, "out_eflags", out_eflags, e_efl);
    chk(out_cs == e_cs, "out_cs", 32'(out_cs), 32'(e_cs));
    chk(out_eip == e_eip, "out_eip", out_eip, e_eip);
    // R12 selector decode of the result
    chk(out_cs_table == e_cs[2], "R12 table bit", 32'(out_cs_table), 32'(e_cs[2]));
    chk(out_cs_off == {e_cs[15:3], 3'b000}, "R12 offset", 32'(out_cs_off), 32'({e_cs[15:3], 3'b000}));
    chk(out_cpl == e_cs[1:0], "R12 ring", 32'(out_cpl), 32'(e_cs[1:0]));
    chk(exp_wa.size() == 0, "missing writes", 32'(exp_wa.size()), 32'h0);
    chk(exp_ra.size() == 0, "missing reads", 32'(exp_ra.size()), 32'h0);
    @(negedge clk);
    chk(!done, "R11 done is one cycle", 32'(done), 32'h0);
    repeat (3) @(negedge clk);
  endtask

  // noise: 0 none, 1 both requests together, 2 requests while busy
  task automatic run_entry(input int noise);
    model_entry();
    entry_req = 1'b1;
    if (noise == 1) ret_req = 1'b1;
    @(negedge clk);
    entry_req = 1'b0;
    ret_req = 1'b0;
    if (noise == 2) begin
      entry_req = 1'b1; ret_req = 1'b1;
      repeat (2) @(negedge clk);
      entry_req = 1'b0; ret_req = 1'b0;
    end
    wait_and_compare();
  endtask

  task automatic run_ret();
    model_ret();
    ret_req = 1'b1;
    @(negedge clk);
    ret_req = 1'b0;
    wait_and_compare();
  endtask

  task automatic set_ctx(input logic [15:0] ss, input logic [31:0] esp, input logic [31:0] efl,
                         input logic [15:0] cs, input logic [31:0] eip);
    cur_ss = ss; cur_esp = esp; cur_eflags = efl; cur_cs = cs; cur_eip = eip;
  endtask

  task automatic set_handler(input logic [15:0] hcs, input logic [31:0] heip,
                             input logic herr, input logic [31:0] err);
    handler_cs = hcs; handler_eip = heip; has_err = herr; err_code = err;
  endtask

  initial begin
    rst = 1'b1; entry_req = 1'b0; ret_req = 1'b0;
    set_ctx(16'h0, 32'h0, 32'h0, 16'h0, 32'h0);
    set_handler(16'h0, 32'h0, 1'b0, 32'h0);
    inner_ss = 16'h0010; inner_esp = 32'h0000_2000;
    repeat (3) @(negedge clk);
    // R1 reset state
    cur_tag = "R1";
    chk(!busy && !done && !fault, "idle flags", {29'h0, busy, done, fault}, 32'h0);
    chk(!mem_we && !mem_re, "no access", {30'h0, mem_we, mem_re}, 32'h0);
    chk(out_esp == 32'h0 && out_cs == 16'h0, "results zero", out_esp, 32'h0);
    rst = 1'b0;
    @(negedge clk);

    cur_tag = "R2";  // same-ring entry, no error code
    set_ctx(16'h0010, 32'h0000_1000, 32'h0000_0202, 16'h0008, 32'h0000_4000);
    set_handler(16'h0010, 32'h0000_5000, 1'b0, 32'h0);
    run_entry(0);

    cur_tag = "R4";  // same-ring entry with error code
    set_ctx(16'h0010, 32'h0000_0FF4, 32'h0000_0046, 16'h0010, 32'h0000_5010);
    set_handler(16'h0018, 32'h0000_6000, 1'b1, 32'hDEAD_0001);
    run_entry(0);

    cur_tag = "R3";  // inward entry with error code, selectors zero-padded (R5)
    set_ctx(16'h0023, 32'h8000_0100, 32'h0000_3202, 16'h001B, 32'h0804_8000);
    set_handler(16'h0008, 32'hC000_1000, 1'b1, 32'h0000_000E);
    run_entry(0);

    cur_tag = "R8";  // outward return from the frame above, error code already removed
    set_ctx(16'h0010, 32'h0000_1FEC, 32'h0, 16'h0008, 32'h0);
    run_ret();

    cur_tag = "R7";  // same-ring return from the first frame
    set_ctx(16'h0010, 32'h0000_0FF4, 32'h0, 16'h0010, 32'h0);
    run_ret();

    cur_tag = "R6";  // entry toward a less privileged ring
    set_ctx(16'h0010, 32'h0000_0800, 32'h0000_0002, 16'h0008, 32'h0000_1234);
    set_handler(16'h001B, 32'h0000_9999, 1'b1, 32'h5);
    run_entry(0);

    cur_tag = "R9";  // return into a more privileged ring
    mem[32'h3000] = 32'h0000_1111;
    mem[32'h3004] = 32'h0000_0008;
    mem[32'h3008] = 32'h0000_0002;
    mem[32'h300C] = 32'h0000_5555;
    set_ctx(16'h0023, 32'h0000_3000, 32'h0, 16'h002B, 32'h0);
    run_ret();

    cur_tag = "R5";  // upper halves of popped selectors ignored
    mem[32'h4000] = 32'h0000_2222;
    mem[32'h4004] = 32'hABCD_000F;
    mem[32'h4008] = 32'h0000_0046;
    mem[32'h400C] = 32'h7777_0000;
    mem[32'h4010] = 32'hFFFF_0033;
    set_ctx(16'h0010, 32'h0000_4000, 32'h0, 16'h0008, 32'h0);
    run_ret();

    cur_tag = "R11";  // both requests at once: entry wins, no read appears
    set_ctx(16'h0010, 32'h0000_0C00, 32'h0000_0202, 16'h0008, 32'h0000_7000);
    set_handler(16'h0010, 32'h0000_7100, 1'b0, 32'h0);
    run_entry(1);

    cur_tag = "R11";  // requests while busy are ignored (R10 monitor flags any extra access)
    set_ctx(16'h0033, 32'h0001_0000, 32'h0000_0200, 16'h0023, 32'h0000_8000);
    set_handler(16'h0008, 32'h0000_8800, 1'b1, 32'h0000_0007);
    inner_esp = 32'h0000_6000;
    run_entry(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule